// File: doc/BRIEF.md
# Clock-to-Signal Edge Delay Monitor

This block watches two synchronously sampled inputs: a reference clock line and a dependent signal line. It measures how many sample ticks separate an edge on the reference from the next edge on the dependent signal. A free-running timestamp counter advances once per clock. A two-state pairing machine opens a measurement on a reference edge and closes it on a signal edge. When a measurement closes, the block reports the difference in ticks together with a one-cycle valid strobe.

Edges that arrive in the wrong state are counted as misses rather than dropped. A reference edge that arrives while a measurement is open is a missed reference. A signal edge that arrives while no measurement is open is a missed signal. Each kind has its own saturating counter and a one-cycle event pulse. A single sample can move the machine two steps, so edges on both lines in the same sample are paired deterministically. The edge sense of each line is chosen separately. The inputs are assumed to be already synchronous to `clk`.

Top module: `edge_delay_monitor`

## Requirements
- R1: While `rst_n` is low, every output is zero and the machine waits for a reference edge. On the first sample after reset, each line's previous value is loaded from the input, so that sample never counts as an edge.
- R2: Each polarity input selects which transitions qualify. Bit 0 set accepts a low-to-high change and bit 1 set accepts a high-to-low change. So 2'b01 is rising only, 2'b10 is falling only, 2'b11 is either change, and 2'b00 accepts no edge.
- R3: A qualifying reference edge while waiting for a reference opens a measurement at the current timestamp. The next qualifying signal edge closes it. One clock after that signal sample, `delayValid` is high for exactly one cycle and `delayTicks` holds the number of clock cycles between the two samples.
- R4: If qualifying edges on both lines arrive in the same sample while waiting for a reference, the block reports a delay of 0 and keeps waiting for a reference.
- R5: If qualifying edges on both lines arrive in the same sample while a measurement is open, that measurement closes with its delay. A new measurement then opens at that same sample.
- R6: A qualifying signal edge while waiting for a reference pulses `missSigPulse` for one cycle and increments `missSigCount`. This happens only if some signal edge has closed a measurement since reset or clear.
- R7: A qualifying reference edge while a measurement is open pulses `missRefPulse` for one cycle and increments `missRefCount`. The open measurement keeps its original start time.
- R8: Both miss counters saturate at all ones and hold there. The event pulse still fires on each further miss.
- R9: When `clr` is high at a clock edge, both counters and all strobes go to zero and the machine returns to waiting for a reference, forgetting earlier signal edges. Edges seen in that sample are not acted on.
- R10: The delay is the modular difference of the timestamps. A measurement that spans a counter wrap reports the true tick count, provided that count is below 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters and pairing state |
| refIn | input | 1 | Reference clock line, synchronous |
| sigIn | input | 1 | Dependent signal line, synchronous |
| refPol | input | 2 | Edge sense for the reference line |
| sigPol | input | 2 | Edge sense for the signal line |
| delayValid | output | 1 | One-cycle strobe for a completed measurement |
| delayTicks | output | TS_W | Measured delay in ticks |
| missRefPulse | output | 1 | One-cycle pulse on a missed reference edge |
| missSigPulse | output | 1 | One-cycle pulse on a missed signal edge |
| missRefCount | output | MISS_W | Saturating missed-reference count |
| missSigCount | output | MISS_W | Saturating missed-signal count |

## Verification
The bench builds the block with TS_W = 8 and MISS_W = 4 instead of the 32 and 16 used in a chip. With an 8-bit timestamp, the counter wraps after 256 cycles, so a short measurement placed just before the wrap tests the modular subtraction. With 4-bit miss counters, saturation at 15 is reached after a handful of extra reference edges. Both corners stay well inside a short run.

// File: rtl/edm_pkg.sv
package edm_pkg;

  typedef enum logic {
    WAIT_REF = 1'b0,
    WAIT_SIG = 1'b1
  } pairState_t;

  typedef struct packed {
    logic openMeas;
    logic closeMeas;
    logic zeroDelay;
    logic missRef;
    logic missSig;
    logic flush;
  } ctrlStrobe_t;

  localparam int NUM_LINES = 2;
  localparam int LINE_REF  = 0;
  localparam int LINE_SIG  = 1;

endpackage

// File: rtl/edm_edge_detect.sv
module edm_edge_detect (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  logic [1:0] pol,
  output logic       hit
);

  logic prevLevel;
  logic primed;

  // The first sample after reset only loads the history register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLevel <= 1'b0;
      primed    <= 1'b0;
    end else begin
      prevLevel <= level;
      primed    <= 1'b1;
    end
  end

  logic riseSeen;
  logic fallSeen;

  always_comb begin
    riseSeen = !prevLevel && level;
    fallSeen = prevLevel && !level;
    hit      = primed && ((pol[0] && riseSeen) || (pol[1] && fallSeen));
  end

endmodule

// File: rtl/edm_ctrl.sv
module edm_ctrl
  import edm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        refHit,
  input  logic        sigHit,
  output ctrlStrobe_t strobe
);

  pairState_t state;
  pairState_t stateNext;
  logic       sigSeen;
  logic       sigSeenNext;

  // Up to two steps of the pairing machine are folded into one sample.
  always_comb begin
    strobe      = '0;
    stateNext   = state;
    sigSeenNext = sigSeen;
    if (clr) begin
      strobe.flush = 1'b1;
      stateNext    = WAIT_REF;
      sigSeenNext  = 1'b0;
    end else begin
      unique case (state)
        WAIT_REF: begin
          if (refHit && sigHit) begin
            // Open and close within one sample: zero delay, back to waiting.
            strobe.closeMeas = 1'b1;
            strobe.zeroDelay = 1'b1;
            sigSeenNext      = 1'b1;
          end else if (refHit) begin
            strobe.openMeas = 1'b1;
            stateNext       = WAIT_SIG;
          end else if (sigHit && sigSeen) begin
            strobe.missSig = 1'b1;
          end
        end
        WAIT_SIG: begin
          if (sigHit) begin
            strobe.closeMeas = 1'b1;
            sigSeenNext      = 1'b1;
            if (refHit) begin
              // Same reference edge reopens a measurement right away.
              strobe.openMeas = 1'b1;
            end else begin
              stateNext = WAIT_REF;
            end
          end else if (refHit) begin
            strobe.missRef = 1'b1;
          end
        end
        default: stateNext = WAIT_REF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= WAIT_REF;
      sigSeen <= 1'b0;
    end else begin
      state   <= stateNext;
      sigSeen <= sigSeenNext;
    end
  end

endmodule

// File: rtl/edm_datapath.sv
module edm_datapath
  import edm_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int MISS_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  ctrlStrobe_t                       strobe,
  output logic                              delayValid,
  output logic [TS_W-1:0]                   delayTicks,
  output logic [NUM_LINES-1:0]              missPulse,
  output logic [NUM_LINES-1:0][MISS_W-1:0]  missCount
);

  localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

  logic [TS_W-1:0] tsNow;
  logic [TS_W-1:0] measStart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsNow <= '0;
    end else begin
      tsNow <= tsNow + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      measStart <= '0;
    end else if (strobe.openMeas) begin
      measStart <= tsNow;
    end
  end

  // Modular subtraction keeps the result right across a counter wrap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delayValid <= 1'b0;
      delayTicks <= '0;
    end else if (strobe.flush) begin
      delayValid <= 1'b0;
      delayTicks <= '0;
    end else begin
      delayValid <= strobe.closeMeas;
      if (strobe.closeMeas) begin
        delayTicks <= strobe.zeroDelay ? '0 : tsNow - measStart;
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_miss
    logic              bump;
    logic              pulseReg;
    logic [MISS_W-1:0] cntReg;

    assign bump = (g == LINE_REF) ? strobe.missRef : strobe.missSig;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pulseReg <= 1'b0;
        cntReg   <= '0;
      end else if (strobe.flush) begin
        pulseReg <= 1'b0;
        cntReg   <= '0;
      end else begin
        pulseReg <= bump;
        if (bump && (cntReg != MISS_MAX)) begin
          cntReg <= cntReg + 1'b1;
        end
      end
    end

    assign missPulse[g] = pulseReg;
    assign missCount[g] = cntReg;
  end

endmodule

// File: rtl/edge_delay_monitor.sv
module edge_delay_monitor
  import edm_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              refIn,
  input  logic              sigIn,
  input  logic [1:0]        refPol,
  input  logic [1:0]        sigPol,
  output logic              delayValid,
  output logic [TS_W-1:0]   delayTicks,
  output logic              missRefPulse,
  output logic              missSigPulse,
  output logic [MISS_W-1:0] missRefCount,
  output logic [MISS_W-1:0] missSigCount
);

  logic [NUM_LINES-1:0]             lineLevel;
  logic [NUM_LINES-1:0][1:0]        linePol;
  logic [NUM_LINES-1:0]             lineHit;
  logic [NUM_LINES-1:0]             missPulse;
  logic [NUM_LINES-1:0][MISS_W-1:0] missCount;
  ctrlStrobe_t                      strobe;

  assign lineLevel[LINE_REF] = refIn;
  assign lineLevel[LINE_SIG] = sigIn;
  assign linePol[LINE_REF]   = refPol;
  assign linePol[LINE_SIG]   = sigPol;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    edm_edge_detect u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (lineLevel[g]),
      .pol   (linePol[g]),
      .hit   (lineHit[g])
    );
  end

  edm_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .refHit (lineHit[LINE_REF]),
    .sigHit (lineHit[LINE_SIG]),
    .strobe (strobe)
  );

  edm_datapath #(
    .TS_W   (TS_W),
    .MISS_W (MISS_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .delayValid (delayValid),
    .delayTicks (delayTicks),
    .missPulse  (missPulse),
    .missCount  (missCount)
  );

  assign missRefPulse = missPulse[LINE_REF];
  assign missSigPulse = missPulse[LINE_SIG];
  assign missRefCount = missCount[LINE_REF];
  assign missSigCount = missCount[LINE_SIG];

endmodule

// File: rtl/edm_checker.sv
module edm_checker #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              delayValid,
  input logic              missRefPulse,
  input logic              missSigPulse,
  input logic [MISS_W-1:0] missRefCount,
  input logic [MISS_W-1:0] missSigCount
);

  localparam logic [MISS_W-1:0] CNT_TOP = {MISS_W{1'b1}};

  // R6/R7: a missed edge needs opposite states, so both pulses never coincide.
  assert_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(missRefPulse && missSigPulse));

  // R7: a missed reference happens only when no signal edge closed the measurement.
  assert_ref_miss_no_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(missRefPulse && delayValid));

  assert_ref_cnt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((missRefCount != $past(missRefCount)) && !$past(clr)) |-> missRefPulse);

  assert_sig_cnt_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((missSigCount != $past(missSigCount)) && !$past(clr)) |-> missSigPulse);

  assert_ref_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((missRefCount == CNT_TOP) && !clr) |=> (missRefCount == CNT_TOP));

  assert_sig_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((missSigCount == CNT_TOP) && !clr) |=> (missSigCount == CNT_TOP));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (missRefCount == '0 && missSigCount == '0 && !delayValid
             && !missRefPulse && !missSigPulse));

endmodule

bind edge_delay_monitor edm_checker #(.MISS_W(MISS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .clr          (clr),
  .delayValid   (delayValid),
  .missRefPulse (missRefPulse),
  .missSigPulse (missSigPulse),
  .missRefCount (missRefCount),
  .missSigCount (missSigCount)
);

// File: tb/edge_delay_monitor_tb.sv
`timescale 1ns/1ps
module edge_delay_monitor_tb;

  localparam int TS_W   = 8;
  localparam int MISS_W = 4;
  localparam int NV     = 21;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0;
  logic              refIn = 1'b0;
  logic              sigIn = 1'b0;
  logic [1:0]        refPol = 2'b01;
  logic [1:0]        sigPol = 2'b01;
  logic              delayValid;
  logic [TS_W-1:0]   delayTicks;
  logic              missRefPulse;
  logic              missSigPulse;
  logic [MISS_W-1:0] missRefCount;
  logic [MISS_W-1:0] missSigCount;

  int nChecks = 0;
  int nFails  = 0;
  bit runDone = 1'b0;

  always #2 clk = ~clk;

  edge_delay_monitor #(.TS_W(TS_W), .MISS_W(MISS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .refIn(refIn), .sigIn(sigIn),
    .refPol(refPol), .sigPol(sigPol), .delayValid(delayValid),
    .delayTicks(delayTicks), .missRefPulse(missRefPulse),
    .missSigPulse(missSigPulse), .missRefCount(missRefCount),
    .missSigCount(missSigCount)
  );

  // Row: ref, sig, expValid, expDelay[8], expMissRef, expMissSig, expCntRef[4], expCntSig[4]
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd0},  // 0 priming sample
    {1'b1,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd0},  // 1 open
    {1'b1,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd0},
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd0},  // falling ignored
    {1'b0,1'b1, 1'b1,8'd3, 1'b0,1'b0, 4'd0,4'd0},  // 4 close, R3
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd0},
    {1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b1, 4'd0,4'd1},  // 6 missed signal, R6
    {1'b1,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd1},  // 7 open
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd0,4'd1},
    {1'b1,1'b0, 1'b0,8'd0, 1'b1,1'b0, 4'd1,4'd1},  // 9 missed reference, R7
    {1'b0,1'b1, 1'b1,8'd3, 1'b0,1'b0, 4'd1,4'd1},  // 10 start kept at 7
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd1},
    {1'b1,1'b1, 1'b1,8'd0, 1'b0,1'b0, 4'd1,4'd1},  // 12 R4 zero delay
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd1},
    {1'b0,1'b1, 1'b0,8'd0, 1'b0,1'b1, 4'd1,4'd2},  // 14 still waiting for ref
    {1'b1,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd2},  // 15 open
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd2},
    {1'b1,1'b1, 1'b1,8'd2, 1'b0,1'b0, 4'd1,4'd2},  // 17 R5 close and reopen
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd2},
    {1'b0,1'b1, 1'b1,8'd2, 1'b0,1'b0, 4'd1,4'd2},  // 19 R5 second close
    {1'b0,1'b0, 1'b0,8'd0, 1'b0,1'b0, 4'd1,4'd2}
  };

  function automatic string rowReq(int i);
    if (i == 12) return "R4";
    if (i == 17 || i == 19) return "R5";
    return "R3";
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chkEq(string req, string what, longint act, longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // Called at a negedge; drives, lets one posedge sample, returns at next negedge.
  task automatic step(bit r, bit s);
    refIn = r;
    sigIn = s;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(bit r, bit s, logic [1:0] rp, logic [1:0] sp);
    @(negedge clk);
    rst_n = 1'b0; clr = 1'b0; refIn = r; sigIn = s; refPol = rp; sigPol = sp;
    repeat (2) @(negedge clk);
    chkEq("R1", "reset delayValid", delayValid, 0);
    chkEq("R1", "reset counts", {missRefCount, missSigCount}, 0);
    chkEq("R1", "reset pulses", {missRefPulse, missSigPulse}, 0);
    rst_n = 1'b1;
    step(r, s);
    chkEq("R1", "priming sample valid", delayValid, 0);
  endtask

  initial begin
    // Table walk
    doReset(1'b0, 1'b0, 2'b01, 2'b01);
    for (int i = 1; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      step(v[20], v[19]);
      chkEq(rowReq(i), $sformatf("row %0d delayValid", i), delayValid, v[18]);
      if (v[18]) chkEq(rowReq(i), $sformatf("row %0d delayTicks", i), delayTicks, v[17:10]);
      chkEq("R7", $sformatf("row %0d missRefPulse", i), missRefPulse, v[9]);
      chkEq("R6", $sformatf("row %0d missSigPulse", i), missSigPulse, v[8]);
      chkEq("R7", $sformatf("row %0d missRefCount", i), missRefCount, v[7:4]);
      chkEq("R6", $sformatf("row %0d missSigCount", i), missSigCount, v[3:0]);
    end

    // R1: high reference held through reset is not an edge on the first sample
    doReset(1'b1, 1'b0, 2'b01, 2'b01);
    step(1'b1, 1'b1);
    chkEq("R1", "no open from primed level", delayValid, 0);
    chkEq("R6", "no miss before any signal edge", missSigPulse, 0);

    // R2: falling reference, either-sense signal
    doReset(1'b1, 1'b0, 2'b10, 2'b11);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chkEq("R2", "falling ref to rising sig valid", delayValid, 1);
    chkEq("R2", "falling ref to rising sig delay", delayTicks, 2);
    step(1'b1, 1'b1);
    chkEq("R2", "rising ref ignored", delayValid | missSigPulse, 0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chkEq("R2", "falling sig accepted valid", delayValid, 1);
    chkEq("R2", "falling sig accepted delay", delayTicks, 1);

    // R2: polarity 00 accepts nothing
    doReset(1'b0, 1'b0, 2'b00, 2'b01);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    chkEq("R2", "disabled ref never opens", delayValid, 0);

    // R3: valid lasts one cycle
    doReset(1'b0, 1'b0, 2'b01, 2'b01);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chkEq("R3", "close valid", delayValid, 1);
    chkEq("R3", "close delay", delayTicks, 1);
    step(1'b1, 1'b1);
    chkEq("R3", "valid is single cycle", delayValid, 0);

    // R8: saturation of the missed-reference counter
    doReset(1'b0, 1'b0, 2'b01, 2'b01);
    step(1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end
    chkEq("R8", "missRefCount saturated", missRefCount, 15);
    chkEq("R8", "pulse still fires at saturation", missRefPulse, 1);

    // R9: clear wipes counts and pairing state
    clr = 1'b1;
    step(1'b0, 1'b1);
    clr = 1'b0;
    chkEq("R9", "counts cleared", {missRefCount, missSigCount}, 0);
    chkEq("R9", "no valid after clear", delayValid, 0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    chkEq("R9", "signal edge after clear is no miss", missSigPulse | delayValid, 0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chkEq("R9", "fresh measurement after clear", delayValid, 1);
    chkEq("R9", "fresh measurement delay", delayTicks, 2);

    // R10: measurement across timestamp wrap
    doReset(1'b0, 1'b0, 2'b01, 2'b01);
    for (int k = 0; k < 250; k++) step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    for (int k = 0; k < 9; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chkEq("R10", "wrap valid", delayValid, 1);
    chkEq("R10", "wrap delay", delayTicks, 10);

    runDone = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!runDone) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule